// File: doc/BRIEF.md
# Majority-Vote Lane Sampler

This block resolves one stable bit per byte lane from a noisy status source. The byte lanes sit in modules of two lanes each. For each active module the block triggers a test access on a traffic generator and waits for its acknowledge. It then reads that module's status word. It repeats this a parameterised number of times. Once every sample of a module is in, it takes a strict majority vote for each of the module's two lanes and writes the two results into a packed vector.

A training sequencer raises `start` with the sampling mode and the channel width. It waits for the one-cycle `done` pulse and then reads `result`. The mode picks which status bits are tapped, one set for receive-enable training and one set for write-strobe training. In 16-bit channel mode only half of the byte lanes, and so half of the modules, are swept.

Top module: `lane_vote_sampler`

## Requirements
- R1: The result bit for lane l (0 or 1) of module g is driven at `result[l + 2*g]`.
- R2: With `wstrobe_mode` = 0 at start, lane 0 of each module votes on status bit 1 and lane 1 votes on status bit 0.
- R3: With `wstrobe_mode` = 1 at start, lane 0 of each module votes on status bit 9 and lane 1 votes on status bit 8.
- R4: A result bit is 1 only when its ones count is strictly greater than its zeros count among the SAMPLES samples. A tie gives 0.
- R5: Modules are swept in ascending order. Each module gets exactly SAMPLES access/read pairs, and each read addresses that module on `rd_group`. The votes for a module are formed only after all of its samples are taken.
- R6: With `half_width` = 1 at start, only modules 0 to GROUPS/2-1 are sampled and their lanes are voted. All higher result bits stay 0.
- R7: `acc_first` is 1 on the first test access after an accepted start and 0 on every later access of that run.
- R8: An accepted start clears `result` to 0 on the next cycle.
- R9: `done` is high for exactly one cycle when the last vote is written. `result` then holds its value until the next accepted start.
- R10: A `start` pulse while a run is in progress has no effect on that run's accesses or results.
- R11: `acc_req` stays high until `acc_ack`, and `rd_req` stays high until `rd_valid`. The two requests are never high in the same cycle, and each read follows an acknowledged access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| wstrobe_mode | input | 1 | 0: receive-enable taps, 1: write-strobe taps |
| half_width | input | 1 | 1: 16-bit channel, sweep half the modules |
| acc_req | output | 1 | Test access request to traffic generator |
| acc_first | output | 1 | Marks the first access of a run |
| acc_ack | input | 1 | Traffic generator access complete |
| rd_req | output | 1 | Status word read request |
| rd_group | output | GW | Module whose status word is read |
| rd_valid | input | 1 | Status read data valid |
| rd_data | input | STAT_W | Status word |
| done | output | 1 | One-cycle completion pulse |
| result | output | LANES | Resolved bit per byte lane |

## Verification
The bench runs with an even sample count so that exact ties occur. A design that treated a tie as a pass, by using greater-or-equal, would report 1 on those lanes. Every status word also carries random values on the taps of the other mode. A design that swapped the lane taps or ignored the mode would then vote on the wrong bits and produce mismatched lane results. Half-width runs check that the upper lanes stay clear and that the access count halves. Other runs check the first-run flag across accesses and a stray start pulse in the middle of a run. Either error would show up as a wrong flag or an extra sweep.

// File: rtl/lane_vote_sampler.sv
module lane_vote_sampler #(
  parameter int LANES   = 4,
  parameter int SAMPLES = 5,
  parameter int STAT_W  = 32,
  localparam int GROUPS = LANES / 2,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wstrobe_mode,
  input  logic              half_width,
  output logic              acc_req,
  output logic              acc_first,
  input  logic              acc_ack,
  output logic              rd_req,
  output logic [GW-1:0]     rd_group,
  input  logic              rd_valid,
  input  logic [STAT_W-1:0] rd_data,
  output logic              done,
  output logic [LANES-1:0]  result
);
  localparam int CW = $clog2(SAMPLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_RD, S_VOTE, S_DONE} state_t;
  state_t state;

  logic          mode_q, half_q, first_q;
  logic [GW-1:0] grp;
  logic [CW-1:0] smp, ones0, ones1;
  logic [GW-1:0] last_grp;
  logic          tap0, tap1, vote0, vote1;
  logic          unused_bits;

  assign last_grp    = half_q ? GW'(GROUPS / 2 - 1) : GW'(GROUPS - 1);
  assign tap0        = mode_q ? rd_data[9] : rd_data[1];
  assign tap1        = mode_q ? rd_data[8] : rd_data[0];
  assign vote0       = {ones0, 1'b0} > (CW + 1)'(SAMPLES);
  assign vote1       = {ones1, 1'b0} > (CW + 1)'(SAMPLES);
  assign unused_bits = ^rd_data;

  assign acc_req   = (state == S_ACC);
  assign acc_first = acc_req & first_q;
  assign rd_req    = (state == S_RD);
  assign rd_group  = grp;
  assign done      = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      mode_q  <= 1'b0;
      half_q  <= 1'b0;
      first_q <= 1'b0;
      grp     <= '0;
      smp     <= '0;
      ones0   <= '0;
      ones1   <= '0;
      result  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_ACC;
          mode_q  <= wstrobe_mode;
          half_q  <= half_width;
          first_q <= 1'b1;
          grp     <= '0;
          smp     <= '0;
          ones0   <= '0;
          ones1   <= '0;
          result  <= '0;
        end
        S_ACC: if (acc_ack) begin
          first_q <= 1'b0;
          state   <= S_RD;
        end
        S_RD: if (rd_valid) begin
          ones0 <= ones0 + CW'(tap0);
          ones1 <= ones1 + CW'(tap1);
          if (smp == CW'(SAMPLES - 1)) begin
            smp   <= '0;
            state <= S_VOTE;
          end else begin
            smp   <= smp + 1'b1;
            state <= S_ACC;
          end
        end
        S_VOTE: begin
          for (int g = 0; g < GROUPS; g++) begin
            if (grp == GW'(g)) begin
              result[2*g]   <= vote0;
              result[2*g+1] <= vote1;
            end
          end
          ones0 <= '0;
          ones1 <= '0;
          if (grp == last_grp) state <= S_DONE;
          else begin
            grp   <= grp + 1'b1;
            state <= S_ACC;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_req && rd_req));
  p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req);
  p_rd_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_ack |=> rd_req);
  p_first_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_ack |=> !acc_first);
  p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && start |=> result == '0);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && !start |=> $stable(result));
  p_group_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_group <= last_grp);
endmodule

// File: tb/test_lane_vote_sampler.sv
module test_lane_vote_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int NSAMP  = 4;
  localparam int GROUPS = LANES / 2;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic clk = 0, rst_n = 0, start = 0, wstrobe_mode = 0, half_width = 0;
  logic acc_req, acc_first, acc_ack = 0, rd_req, rd_valid = 0, done;
  logic [GW-1:0] rd_group;
  logic [31:0] rd_data = '0;
  logic [LANES-1:0] result;

  int checks = 0, errors = 0;
  logic [31:0] stim [GROUPS][NSAMP];
  int idx [GROUPS];
  int acc_cnt = 0;
  bit first_exp = 0;
  logic [LANES-1:0] exp_q [$];
  int cnt_q [$];
  logic [LANES-1:0] last_exp;
  int unsigned lcg = 32'h1234_5678;

  lane_vote_sampler #(.LANES(LANES), .SAMPLES(NSAMP), .STAT_W(32)) i_lane_vote_sampler (
    .clk, .rst_n, .start, .wstrobe_mode, .half_width, .acc_req, .acc_first, .acc_ack,
    .rd_req, .rd_group, .rd_valid, .rd_data, .done, .result);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  // responder: traffic generator and status read port (R7, R11)
  always @(negedge clk) begin
    if (acc_req && !acc_ack) begin
      acc_ack <= 1'b1;
      chk(acc_first == first_exp, "R7 first-run flag", acc_first, first_exp);
      first_exp = 0;
      acc_cnt++;
    end else acc_ack <= 1'b0;
    if (rd_req && !rd_valid) begin
      chk(int'(rd_group) < GROUPS, "R5 group range", rd_group, GROUPS);
      rd_valid <= 1'b1;
      rd_data  <= stim[rd_group][idx[rd_group]];
      idx[rd_group]++;
    end else rd_valid <= 1'b0;
  end

  // monitor: scoreboard compare at done (R1-R6, R10)
  always @(negedge clk) begin
    if (done && exp_q.size() > 0) begin
      logic [LANES-1:0] e;
      int c;
      e = exp_q.pop_front();
      c = cnt_q.pop_front();
      last_exp = e;
      chk(result == e, "R1-lane-result R2 R3 R4", result, e);
      chk(acc_cnt == c, "R5 R6 R10 access count", acc_cnt, c);
    end
  end

  function automatic logic [LANES-1:0] model(input bit mode, input bit half);
    logic [LANES-1:0] r = '0;
    int ng = half ? GROUPS / 2 : GROUPS;
    for (int g = 0; g < ng; g++)
      for (int l = 0; l < 2; l++) begin
        int ones = 0;
        for (int s = 0; s < NSAMP; s++)
          ones += mode ? stim[g][s][9-l] : stim[g][s][1-l];
        r[l + 2*g] = (2 * ones > NSAMP);
      end
    return r;
  endfunction

  task automatic run(input bit mode, input bit half, input bit stray, input string tag);
    int ng = half ? GROUPS / 2 : GROUPS;
    for (int g = 0; g < GROUPS; g++) idx[g] = 0;
    acc_cnt = 0;
    first_exp = 1;
    exp_q.push_back(model(mode, half));
    cnt_q.push_back(ng * NSAMP);
    @(negedge clk);
    start = 1; wstrobe_mode = mode; half_width = half;
    @(negedge clk);
    start = 0; wstrobe_mode = ~mode; half_width = ~half;
    chk(result == '0, {"R8 clear on start ", tag}, result, 0);
    if (stray) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 0, {"R9 done pulse ", tag}, done, 0);
    repeat (4) @(negedge clk);
    chk(result == last_exp, {"R9 hold ", tag}, result, last_exp);
    for (int g = 0; g < GROUPS; g++)
      chk(idx[g] == ((g < ng) ? NSAMP : 0), {"R5 R6 reads per module ", tag}, idx[g],
          (g < ng) ? NSAMP : 0);
  endtask

  task automatic fill_random();
    for (int g = 0; g < GROUPS; g++)
      for (int s = 0; s < NSAMP; s++) stim[g][s] = nxt();
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk);
    chk(result == '0 && done == 0, "R9 reset state", result, 0);
    chk(acc_req == 0 && rd_req == 0, "R11 reset idle", {acc_req, rd_req}, 0);
    rst_n = 1;
    @(negedge clk);
    // R4 tie: lane0 of module 0 has 2/4 ones on bit 1; lane1 3/4 on bit 0
    for (int g = 0; g < GROUPS; g++)
      for (int s = 0; s < NSAMP; s++) stim[g][s] = 32'h0000_0300;
    stim[0][0][1] = 1; stim[0][1][1] = 1;
    stim[0][0][0] = 1; stim[0][1][0] = 1; stim[0][2][0] = 1;
    stim[1][0][1] = 1; stim[1][1][1] = 1; stim[1][2][1] = 1; stim[1][3][1] = 1;
    run(0, 0, 0, "R4 tie rcven");
    chk(result == 4'b0110, "R4 R2 R1 tie value", result, 4'b0110);
    // R3 write-strobe taps with opposite bits in the other mode's taps
    for (int g = 0; g < GROUPS; g++)
      for (int s = 0; s < NSAMP; s++) stim[g][s] = 32'h0000_0003;
    for (int s = 0; s < 3; s++) stim[1][s][8] = 1;
    stim[0][0][9] = 1; stim[0][1][9] = 1; stim[0][2][9] = 1;
    run(1, 0, 0, "R3 wstrobe");
    chk(result == 4'b1001, "R3 R1 value", result, 4'b1001);
    // R6 half width
    fill_random();
    for (int s = 0; s < NSAMP; s++) stim[1][s] = 32'hFFFF_FFFF;
    run(0, 1, 0, "R6 half rcven");
    chk(result[3:2] == 2'b00, "R6 upper lanes clear", result[3:2], 0);
    fill_random();
    run(1, 1, 0, "R6 half wstrobe");
    // R10 stray start
    fill_random();
    run(1, 0, 1, "R10 stray start");
    for (int k = 0; k < 6; k++) begin
      fill_random();
      run(k[0], 0, 0, "R2 R3 random");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule